// File: doc/BRIEF.md
# 1-Wire Switch Transaction Monitor

This block is a passive observer on a 1-Wire bus that talks to an eight-channel addressable switch. It does not see bus timing. An upstream decoder hands it three kinds of single-cycle events: a bus reset with the sampled presence bit, the end of a 64-bit ROM identifier, and a received data byte. From these events the monitor follows each function-command transaction and reports what it finds as one-cycle result pulses. The results are the recognised command, the 16-bit target address, payload and sample bytes, the outcome of the complement check on write data, and the meaning of confirmation bytes.

The byte count restarts on every bus reset event and every ROM-complete event, so the following data byte is always read as a command. The command byte then fixes how the later bytes are read. Integration is a matter of wiring the event strobes from the byte-level decoder and collecting the pulses into a trace or a scoreboard.

Top module: `ow_switch_mon`

## Requirements
- R1: A cycle with `evt_reset` high gives `rst_seen` high in the next cycle, with `presence_out` equal to the `presence_in` value sampled with the event.
- R2: A cycle with `evt_rom` high gives `rom_seen` high in the next cycle, with `family_out` equal to bits 7:0 of `rom_in`.
- R3: The first accepted byte after a reset or ROM event, or after the block's own reset, is the command. A known command pulses `cmd_seen` and sets `cmd_kind`. The encodings are 1 for 0xF0 (read registers), 2 for 0xF5 (channel read), 3 for 0x5A (channel write), 4 for 0xCC (write search register), 5 for 0xC3 (clear activity) and 6 for 0x3C (leave test mode).
- R4: Any other command byte pulses `cmd_unknown` and leaves `cmd_seen` low.
- R5: Under 0xF0 or 0xCC, the third byte pulses `addr_valid`. `addr_out` then holds the third byte in bits 15:8 and the second byte in bits 7:0. The second byte alone gives no pulse.
- R6: Under 0xF0 or 0xCC, every byte from the fourth on pulses `data_valid`, with the byte on `data_out`.
- R7: Under 0xF5, every byte after the command pulses `sample_valid`, with the byte on `data_out`.
- R8: Under 0x5A, the third byte pulses `inv_ok` if it is the bitwise complement of the second byte, and pulses `inv_err` if it is not. The second byte alone gives no pulse.
- R9: Under 0x5A, a byte from the fourth on pulses `stat_success` if it is 0xAA and `stat_failnew` if it is 0xFF. Any other value gives no pulse.
- R10: Under 0xC3, each byte after the command pulses `stat_success` if it is 0xAA and `stat_invalid` otherwise.
- R11: After 0x3C or an unrecognised command, later bytes give no pulse until the next reset or ROM event.
- R12: Position tracking saturates, so a transaction of any length keeps its per-byte meaning and never wraps back to command decoding.
- R13: Every result is a pulse lasting one cycle, in the cycle after its event. A byte strobed in the same cycle as a reset or ROM event is discarded, while that event is still reported. A reset event and a ROM event in the same cycle are both reported.
- R14: While `rst_n` is low, all pulse outputs are low and the transaction state is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_reset | input | 1 | Bus reset/presence event strobe |
| presence_in | input | 1 | Presence bit carried by the reset event |
| evt_rom | input | 1 | ROM-complete event strobe |
| rom_in | input | 64 | ROM identifier carried by the ROM event |
| evt_byte | input | 1 | Data byte strobe |
| byte_in | input | 8 | Data byte value |
| rst_seen | output | 1 | Reset event reported |
| presence_out | output | 1 | Presence bit of the last reset event |
| rom_seen | output | 1 | ROM event reported |
| family_out | output | 8 | Family code of the last ROM event |
| cmd_seen | output | 1 | Known command reported |
| cmd_unknown | output | 1 | Unrecognised command reported |
| cmd_kind | output | 3 | Command encoding, valid with cmd_seen |
| addr_valid | output | 1 | Target address reported |
| addr_out | output | 16 | Target address |
| data_valid | output | 1 | Register data byte reported |
| sample_valid | output | 1 | Channel sample byte reported |
| data_out | output | 8 | Data or sample byte |
| inv_ok | output | 1 | Complement check passed |
| inv_err | output | 1 | Complement check failed |
| stat_success | output | 1 | Confirmation byte 0xAA seen |
| stat_failnew | output | 1 | Confirmation byte 0xFF seen on channel write |
| stat_invalid | output | 1 | Bad confirmation byte on clear activity |

## Verification
A data byte strobe can land in the same cycle as a bus reset or ROM event, and a reset and a ROM event can also coincide. The bench drives these collisions in the middle of an open channel-read stream. It then checks that the reset or ROM pulse still appears, that no byte result pulses in that cycle, and that the next byte is decoded as a fresh command and not as a stale sample. The coinciding reset and ROM case is judged by both pulses appearing together, each with its own value.

// File: rtl/ow_mon_pkg.sv
package ow_mon_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 2 * BYTE_W;

  localparam logic [BYTE_W-1:0] OP_RD_REGS  = 8'hF0;
  localparam logic [BYTE_W-1:0] OP_CH_READ  = 8'hF5;
  localparam logic [BYTE_W-1:0] OP_CH_WRITE = 8'h5A;
  localparam logic [BYTE_W-1:0] OP_WR_SRCH  = 8'hCC;
  localparam logic [BYTE_W-1:0] OP_CLR_ACT  = 8'hC3;
  localparam logic [BYTE_W-1:0] OP_TEST_OFF = 8'h3C;

  localparam logic [BYTE_W-1:0] ACK_GOOD = 8'hAA;
  localparam logic [BYTE_W-1:0] ACK_BAD  = 8'hFF;

  typedef enum logic [2:0] {
    CMD_NONE     = 3'd0,
    CMD_RD_REGS  = 3'd1,
    CMD_CH_READ  = 3'd2,
    CMD_CH_WRITE = 3'd3,
    CMD_WR_SRCH  = 3'd4,
    CMD_CLR_ACT  = 3'd5,
    CMD_TEST_OFF = 3'd6,
    CMD_UNKNOWN  = 3'd7
  } cmd_e;

  typedef struct packed {
    logic cmd;
    logic unk;
    logic addr;
    logic data;
    logic samp;
    logic inv_ok;
    logic inv_err;
    logic ok;
    logic failnew;
    logic invalid;
  } res_t;
endpackage

// File: rtl/ow_mon_cmd_decode.sv
module ow_mon_cmd_decode
  import ow_mon_pkg::*;
(
  input  logic [BYTE_W-1:0] code_i,
  output cmd_e              kind_o
);
  always_comb begin
    unique case (code_i)
      OP_RD_REGS:  kind_o = CMD_RD_REGS;
      OP_CH_READ:  kind_o = CMD_CH_READ;
      OP_CH_WRITE: kind_o = CMD_CH_WRITE;
      OP_WR_SRCH:  kind_o = CMD_WR_SRCH;
      OP_CLR_ACT:  kind_o = CMD_CLR_ACT;
      OP_TEST_OFF: kind_o = CMD_TEST_OFF;
      default:     kind_o = CMD_UNKNOWN;
    endcase
  end
endmodule

// File: rtl/ow_mon_seq.sv
module ow_mon_seq
  import ow_mon_pkg::*;
#(
  parameter int CNT_MAX = 4,
  localparam int CNT_W = $clog2(CNT_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_i,
  input  logic              take_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  cmd_e              kind_i,
  output logic [CNT_W-1:0]  cnt_o,
  output cmd_e              cmd_o,
  output logic [BYTE_W-1:0] stash_o
);
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  cmd_e              cmd_q, cmd_d;
  logic [BYTE_W-1:0] stash_q;
  logic              cnt_en, cmd_en, stash_en;

  always_comb begin
    cnt_d    = cnt_q;
    cmd_d    = cmd_q;
    cnt_en   = 1'b0;
    cmd_en   = 1'b0;
    stash_en = 1'b0;
    if (sync_i) begin
      cnt_d  = '0;
      cmd_d  = CMD_NONE;
      cnt_en = 1'b1;
      cmd_en = 1'b1;
    end else if (take_i) begin
      if (cnt_q != CNT_W'(CNT_MAX)) begin
        cnt_d  = cnt_q + CNT_W'(1);
        cnt_en = 1'b1;
      end
      if (cnt_q == '0) begin
        cmd_d  = kind_i;
        cmd_en = 1'b1;
      end
      if (cnt_q == CNT_W'(1)) begin
        stash_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      cmd_q   <= CMD_NONE;
      stash_q <= '0;
    end else begin
      if (cnt_en)   cnt_q   <= cnt_d;
      if (cmd_en)   cmd_q   <= cmd_d;
      if (stash_en) stash_q <= byte_i;
    end
  end

  assign cnt_o   = cnt_q;
  assign cmd_o   = cmd_q;
  assign stash_o = stash_q;
endmodule

// File: rtl/ow_mon_report.sv
module ow_mon_report
  import ow_mon_pkg::*;
#(
  parameter int FAM_W = 8,
  parameter int CNT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_reset_i,
  input  logic              presence_i,
  input  logic              evt_rom_i,
  input  logic [FAM_W-1:0]  family_i,
  input  logic              take_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  cmd_e              cmd_i,
  input  logic [BYTE_W-1:0] stash_i,
  input  cmd_e              kind_i,
  output res_t              res_o,
  output logic              rst_seen_o,
  output logic              presence_o,
  output logic              rom_seen_o,
  output logic [FAM_W-1:0]  family_o,
  output cmd_e              kind_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BYTE_W-1:0] data_o
);
  res_t res_d, res_q;
  logic kind_en, addr_en, data_en;
  logic pos_cmd, pos_third, pos_later;
  logic rst_seen_q, presence_q, rom_seen_q;
  logic [FAM_W-1:0]  family_q;
  cmd_e              kind_q;
  logic [ADDR_W-1:0] addr_q;
  logic [BYTE_W-1:0] data_q;

  assign pos_cmd   = (cnt_i == '0);
  assign pos_third = (cnt_i == CNT_W'(2));
  assign pos_later = (cnt_i >= CNT_W'(3));

  always_comb begin
    res_d   = '0;
    kind_en = 1'b0;
    addr_en = 1'b0;
    data_en = 1'b0;
    if (take_i) begin
      if (pos_cmd) begin
        kind_en = 1'b1;
        if (kind_i == CMD_UNKNOWN) res_d.unk = 1'b1;
        else                       res_d.cmd = 1'b1;
      end else begin
        unique case (cmd_i)
          CMD_RD_REGS, CMD_WR_SRCH: begin
            if (pos_third) begin
              res_d.addr = 1'b1;
              addr_en    = 1'b1;
            end else if (pos_later) begin
              res_d.data = 1'b1;
              data_en    = 1'b1;
            end
          end
          CMD_CH_READ: begin
            res_d.samp = 1'b1;
            data_en    = 1'b1;
          end
          CMD_CH_WRITE: begin
            if (pos_third) begin
              if (byte_i == ~stash_i) res_d.inv_ok  = 1'b1;
              else                    res_d.inv_err = 1'b1;
            end else if (pos_later) begin
              if (byte_i == ACK_GOOD)     res_d.ok      = 1'b1;
              else if (byte_i == ACK_BAD) res_d.failnew = 1'b1;
            end
          end
          CMD_CLR_ACT: begin
            if (byte_i == ACK_GOOD) res_d.ok      = 1'b1;
            else                    res_d.invalid = 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q      <= '0;
      rst_seen_q <= 1'b0;
      rom_seen_q <= 1'b0;
      presence_q <= 1'b0;
      family_q   <= '0;
      kind_q     <= CMD_NONE;
      addr_q     <= '0;
      data_q     <= '0;
    end else begin
      res_q      <= res_d;
      rst_seen_q <= evt_reset_i;
      rom_seen_q <= evt_rom_i;
      if (evt_reset_i) presence_q <= presence_i;
      if (evt_rom_i)   family_q   <= family_i;
      if (kind_en)     kind_q     <= kind_i;
      if (addr_en)     addr_q     <= {byte_i, stash_i};
      if (data_en)     data_q     <= byte_i;
    end
  end

  assign res_o      = res_q;
  assign rst_seen_o = rst_seen_q;
  assign presence_o = presence_q;
  assign rom_seen_o = rom_seen_q;
  assign family_o   = family_q;
  assign kind_o     = kind_q;
  assign addr_o     = addr_q;
  assign data_o     = data_q;
endmodule

// File: rtl/ow_switch_mon.sv
module ow_switch_mon
  import ow_mon_pkg::*;
#(
  parameter int ROM_W   = 64,
  parameter int FAM_W   = 8,
  parameter int CNT_MAX = 4,
  localparam int CNT_W  = $clog2(CNT_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_reset,
  input  logic              presence_in,
  input  logic              evt_rom,
  input  logic [ROM_W-1:0]  rom_in,
  input  logic              evt_byte,
  input  logic [7:0]        byte_in,
  output logic              rst_seen,
  output logic              presence_out,
  output logic              rom_seen,
  output logic [FAM_W-1:0]  family_out,
  output logic              cmd_seen,
  output logic              cmd_unknown,
  output logic [2:0]        cmd_kind,
  output logic              addr_valid,
  output logic [15:0]       addr_out,
  output logic              data_valid,
  output logic              sample_valid,
  output logic [7:0]        data_out,
  output logic              inv_ok,
  output logic              inv_err,
  output logic              stat_success,
  output logic              stat_failnew,
  output logic              stat_invalid
);
  logic              sync_ev, take_ev;
  cmd_e              dec_kind, cur_cmd, rep_kind;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] stash;
  res_t              res;
  logic              unused_rom_hi;

  assign sync_ev       = evt_reset | evt_rom;
  assign take_ev       = evt_byte & ~sync_ev;
  assign unused_rom_hi = ^rom_in[ROM_W-1:FAM_W];

  ow_mon_cmd_decode u_dec (
    .code_i (byte_in),
    .kind_o (dec_kind)
  );

  ow_mon_seq #(.CNT_MAX(CNT_MAX)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .sync_i  (sync_ev),
    .take_i  (take_ev),
    .byte_i  (byte_in),
    .kind_i  (dec_kind),
    .cnt_o   (cnt),
    .cmd_o   (cur_cmd),
    .stash_o (stash)
  );

  ow_mon_report #(.FAM_W(FAM_W), .CNT_W(CNT_W)) u_rep (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt_reset_i (evt_reset),
    .presence_i  (presence_in),
    .evt_rom_i   (evt_rom),
    .family_i    (rom_in[FAM_W-1:0]),
    .take_i      (take_ev),
    .byte_i      (byte_in),
    .cnt_i       (cnt),
    .cmd_i       (cur_cmd),
    .stash_i     (stash),
    .kind_i      (dec_kind),
    .res_o       (res),
    .rst_seen_o  (rst_seen),
    .presence_o  (presence_out),
    .rom_seen_o  (rom_seen),
    .family_o    (family_out),
    .kind_o      (rep_kind),
    .addr_o      (addr_out),
    .data_o      (data_out)
  );

  assign cmd_kind     = rep_kind;
  assign cmd_seen     = res.cmd;
  assign cmd_unknown  = res.unk;
  assign addr_valid   = res.addr;
  assign data_valid   = res.data;
  assign sample_valid = res.samp;
  assign inv_ok       = res.inv_ok;
  assign inv_err      = res.inv_err;
  assign stat_success = res.ok;
  assign stat_failnew = res.failnew;
  assign stat_invalid = res.invalid;
endmodule

// File: rtl/ow_switch_mon_chk.sv
module ow_switch_mon_chk #(
  parameter int FAM_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             evt_reset,
  input logic             presence_in,
  input logic             evt_rom,
  input logic [FAM_W-1:0] rom_lo,
  input logic             evt_byte,
  input logic             rst_seen,
  input logic             presence_out,
  input logic             rom_seen,
  input logic [FAM_W-1:0] family_out,
  input logic [9:0]       pulses
);
  logic sync_ev;
  assign sync_ev = evt_reset | evt_rom;

  AST_RESET_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
    evt_reset |=> (rst_seen && presence_out == $past(presence_in))); // R1

  AST_FAMILY_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    evt_rom |=> (rom_seen && family_out == $past(rom_lo))); // R2

  AST_FIRST_IS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    sync_ev ##1 (evt_byte && !sync_ev) |=> (pulses[9] || pulses[8])); // R3

  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pulses)); // R13

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_byte |=> (pulses == '0)); // R13

  AST_COLLIDE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_byte && sync_ev) |=> (pulses == '0)); // R13

  always_comb begin
    if (!rst_n) begin
      AST_RESET_QUIET: assert (pulses == '0 && !rst_seen && !rom_seen); // R14
    end
  end
endmodule

bind ow_switch_mon ow_switch_mon_chk #(.FAM_W(FAM_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .evt_reset    (evt_reset),
  .presence_in  (presence_in),
  .evt_rom      (evt_rom),
  .rom_lo       (rom_in[FAM_W-1:0]),
  .evt_byte     (evt_byte),
  .rst_seen     (rst_seen),
  .presence_out (presence_out),
  .rom_seen     (rom_seen),
  .family_out   (family_out),
  .pulses       ({cmd_seen, cmd_unknown, addr_valid, data_valid, sample_valid,
                  inv_ok, inv_err, stat_success, stat_failnew, stat_invalid})
);

// File: tb/tb_ow_switch_mon.sv
`timescale 1ns/1ps
module tb_ow_switch_mon;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        evt_reset, presence_in, evt_rom, evt_byte;
  logic [63:0] rom_in;
  logic [7:0]  byte_in;
  logic        rst_seen, presence_out, rom_seen;
  logic [7:0]  family_out;
  logic        cmd_seen, cmd_unknown, addr_valid, data_valid, sample_valid;
  logic [2:0]  cmd_kind;
  logic [15:0] addr_out;
  logic [7:0]  data_out;
  logic        inv_ok, inv_err, stat_success, stat_failnew, stat_invalid;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  localparam logic [9:0] P_NONE = 10'b0000000000;
  localparam logic [9:0] P_CMD  = 10'b1000000000;
  localparam logic [9:0] P_UNK  = 10'b0100000000;
  localparam logic [9:0] P_ADDR = 10'b0010000000;
  localparam logic [9:0] P_DATA = 10'b0001000000;
  localparam logic [9:0] P_SAMP = 10'b0000100000;
  localparam logic [9:0] P_IOK  = 10'b0000010000;
  localparam logic [9:0] P_IERR = 10'b0000001000;
  localparam logic [9:0] P_OK   = 10'b0000000100;
  localparam logic [9:0] P_FNS  = 10'b0000000010;
  localparam logic [9:0] P_INV  = 10'b0000000001;

  always #5 clk = ~clk;

  ow_switch_mon dut (
    .clk(clk), .rst_n(rst_n), .evt_reset(evt_reset), .presence_in(presence_in),
    .evt_rom(evt_rom), .rom_in(rom_in), .evt_byte(evt_byte), .byte_in(byte_in),
    .rst_seen(rst_seen), .presence_out(presence_out), .rom_seen(rom_seen),
    .family_out(family_out), .cmd_seen(cmd_seen), .cmd_unknown(cmd_unknown),
    .cmd_kind(cmd_kind), .addr_valid(addr_valid), .addr_out(addr_out),
    .data_valid(data_valid), .sample_valid(sample_valid), .data_out(data_out),
    .inv_ok(inv_ok), .inv_err(inv_err), .stat_success(stat_success),
    .stat_failnew(stat_failnew), .stat_invalid(stat_invalid)
  );

  function automatic logic [9:0] pv();
    return {cmd_seen, cmd_unknown, addr_valid, data_valid, sample_valid,
            inv_ok, inv_err, stat_success, stat_failnew, stat_invalid};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    evt_byte = 1'b1;
    byte_in  = b;
    @(negedge clk);
    evt_byte = 1'b0;
  endtask

  task automatic sb(input logic [7:0] b, input string req, input logic [9:0] exp);
    send_byte(b);
    chk(req, {22'd0, pv()}, {22'd0, exp});
  endtask

  task automatic ev_reset(input logic p);
    @(negedge clk);
    evt_reset   = 1'b1;
    presence_in = p;
    @(negedge clk);
    evt_reset = 1'b0;
  endtask

  task automatic ev_rom(input logic [63:0] v);
    @(negedge clk);
    evt_rom = 1'b1;
    rom_in  = v;
    @(negedge clk);
    evt_rom = 1'b0;
  endtask

  task automatic t_reset_state();
    chk("R14 pulses in reset", {22'd0, pv()}, 32'd0);
    chk("R14 event flags in reset", {30'd0, rst_seen, rom_seen}, 32'd0);
  endtask

  task automatic t_events();
    ev_reset(1'b1);
    chk("R1 rst_seen", {31'd0, rst_seen}, 32'd1);
    chk("R1 presence high", {31'd0, presence_out}, 32'd1);
    @(negedge clk);
    chk("R13 rst_seen one cycle", {31'd0, rst_seen}, 32'd0);
    ev_reset(1'b0);
    chk("R1 presence low", {31'd0, presence_out}, 32'd0);
    ev_rom(64'h1122_3344_5566_7729);
    chk("R2 rom_seen", {31'd0, rom_seen}, 32'd1);
    chk("R2 family", {24'd0, family_out}, 32'h29);
  endtask

  task automatic t_read_regs();
    ev_reset(1'b1);
    sb(8'hF0, "R3 cmd F0", P_CMD);
    chk("R3 kind F0", {29'd0, cmd_kind}, 32'd1);
    sb(8'h34, "R5 low addr byte silent", P_NONE);
    sb(8'h12, "R5 addr pulse", P_ADDR);
    chk("R5 addr value", {16'd0, addr_out}, 32'h1234);
    sb(8'h5C, "R6 data pulse", P_DATA);
    chk("R6 data value", {24'd0, data_out}, 32'h5C);
    sb(8'hA7, "R6 second data", P_DATA);
    chk("R6 second data value", {24'd0, data_out}, 32'hA7);
  endtask

  task automatic t_write_search();
    ev_rom(64'hAB00_0000_0000_0029);
    sb(8'hCC, "R3 cmd CC", P_CMD);
    chk("R3 kind CC", {29'd0, cmd_kind}, 32'd4);
    sb(8'h8D, "R5 low addr byte silent", P_NONE);
    sb(8'h00, "R5 addr pulse CC", P_ADDR);
    chk("R5 addr value CC", {16'd0, addr_out}, 32'h008D);
    sb(8'h81, "R6 data CC", P_DATA);
    chk("R6 data value CC", {24'd0, data_out}, 32'h81);
  endtask

  task automatic t_ch_read();
    ev_reset(1'b1);
    sb(8'hF5, "R3 cmd F5", P_CMD);
    chk("R3 kind F5", {29'd0, cmd_kind}, 32'd2);
    sb(8'h0F, "R7 sample", P_SAMP);
    chk("R7 sample value", {24'd0, data_out}, 32'h0F);
    sb(8'hF0, "R7 sample 2", P_SAMP);
    chk("R7 sample value 2", {24'd0, data_out}, 32'hF0);
    sb(8'h96, "R7 sample 3", P_SAMP);
  endtask

  task automatic t_ch_write();
    ev_reset(1'b1);
    sb(8'h5A, "R3 cmd 5A", P_CMD);
    chk("R3 kind 5A", {29'd0, cmd_kind}, 32'd3);
    sb(8'h3C, "R8 data byte silent", P_NONE);
    sb(8'hC3, "R8 inversion ok", P_IOK);
    sb(8'hAA, "R9 success", P_OK);
    sb(8'hFF, "R9 fail new state", P_FNS);
    sb(8'h12, "R9 other silent", P_NONE);
    ev_reset(1'b1);
    sb(8'h5A, "R3 cmd 5A again", P_CMD);
    sb(8'h55, "R8 data byte silent", P_NONE);
    sb(8'h55, "R8 inversion error", P_IERR);
  endtask

  task automatic t_clr_act();
    ev_reset(1'b1);
    sb(8'hC3, "R3 cmd C3", P_CMD);
    chk("R3 kind C3", {29'd0, cmd_kind}, 32'd5);
    sb(8'hAA, "R10 success", P_OK);
    sb(8'h00, "R10 invalid", P_INV);
    sb(8'hFF, "R10 invalid FF", P_INV);
  endtask

  task automatic t_silent_cmds();
    ev_reset(1'b1);
    sb(8'h3C, "R3 cmd 3C", P_CMD);
    chk("R3 kind 3C", {29'd0, cmd_kind}, 32'd6);
    sb(8'hAA, "R11 after 3C", P_NONE);
    sb(8'hF0, "R11 after 3C 2", P_NONE);
    sb(8'hFF, "R11 after 3C 3", P_NONE);
    ev_rom(64'h5);
    sb(8'h96, "R4 unknown cmd", P_UNK);
    sb(8'hF0, "R11 after unknown", P_NONE);
    sb(8'h00, "R11 after unknown 2", P_NONE);
    sb(8'hAA, "R11 after unknown 3", P_NONE);
    sb(8'hAA, "R11 after unknown 4", P_NONE);
  endtask

  task automatic t_long();
    int errs = 0;
    ev_reset(1'b1);
    sb(8'hF0, "R12 cmd", P_CMD);
    sb(8'h00, "R12 addr lo", P_NONE);
    sb(8'h01, "R12 addr hi", P_ADDR);
    for (int i = 0; i < 300; i++) begin
      send_byte(8'(i * 7 + 3));
      if (pv() !== P_DATA || data_out !== 8'(i * 7 + 3)) errs++;
    end
    chk("R12 long stream stays data", errs, 0);
    sb(8'hF0, "R12 opcode value as data", P_DATA);
  endtask

  task automatic t_collide();
    ev_reset(1'b1);
    sb(8'hF5, "R13 prep cmd", P_CMD);
    sb(8'h11, "R13 prep sample", P_SAMP);
    @(negedge clk);
    evt_reset = 1'b1; presence_in = 1'b1; evt_byte = 1'b1; byte_in = 8'h5A;
    @(negedge clk);
    evt_reset = 1'b0; evt_byte = 1'b0;
    chk("R13 reset reported on collision", {31'd0, rst_seen}, 32'd1);
    chk("R13 colliding byte dropped", {22'd0, pv()}, 32'd0);
    sb(8'hF0, "R13 next byte is command", P_CMD);
    chk("R13 kind after collision", {29'd0, cmd_kind}, 32'd1);
    @(negedge clk);
    evt_rom = 1'b1; rom_in = 64'h77; evt_byte = 1'b1; byte_in = 8'hAA;
    @(negedge clk);
    evt_rom = 1'b0; evt_byte = 1'b0;
    chk("R13 rom reported on collision", {31'd0, rom_seen}, 32'd1);
    chk("R13 byte with rom dropped", {22'd0, pv()}, 32'd0);
    sb(8'hF5, "R13 command after rom collision", P_CMD);
    @(negedge clk);
    evt_rom = 1'b1; rom_in = 64'h3A; evt_reset = 1'b1; presence_in = 1'b0;
    @(negedge clk);
    evt_rom = 1'b0; evt_reset = 1'b0;
    chk("R13 reset and rom together", {30'd0, rst_seen, rom_seen}, 32'd3);
    chk("R13 family with reset", {24'd0, family_out}, 32'h3A);
    chk("R13 presence with rom", {31'd0, presence_out}, 32'd0);
  endtask

  task automatic t_hw_reset();
    ev_reset(1'b1);
    sb(8'hF0, "R14 prep cmd", P_CMD);
    send_byte(8'h01);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    sb(8'hF5, "R14 command after hw reset", P_CMD);
    chk("R14 kind after hw reset", {29'd0, cmd_kind}, 32'd2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    evt_reset = 1'b0; presence_in = 1'b0; evt_rom = 1'b0; rom_in = '0;
    evt_byte = 1'b0; byte_in = '0;
    repeat (3) @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    sb(8'hC3, "R3 first byte after hw reset", P_CMD);
    t_events();
    t_read_regs();
    t_write_search();
    t_ch_read();
    t_ch_write();
    t_clr_act();
    t_silent_cmds();
    t_long();
    t_collide();
    t_hw_reset();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule